// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-driven master for the two-wire PHY management bus (IEEE 802.3 Clause 22 framing). Software sets an enable bit and picks an MDC divider. It then writes one 32-bit command word that holds the whole management frame after the preamble: the start pattern, the operation, the PHY address, the register address, the turnaround pattern and the 16-bit data. The block drives a 32-bit preamble of ones on the serial pin and then the command word, most significant bit first, on a clock it divides down from the system clock.

On a read, the block releases the serial data pin for the second turnaround bit and for the 16 data bits. It samples the PHY's reply on the rising edges of MDC and places the captured value in bits 15:0 of the command word. Software reads the result from that word. A status flag reports whether the port is idle. A command written while the port is busy is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the enable bit is 0, the divider select reads 2 (configuration reads 0x00080000), the status idle flag (bit 2) reads 1, the command word reads 0, and MDC and the output enable are low.
- R2: An accepted command produces exactly 64 MDC rising edges. The first 32 bits are ones, and the next 32 are command-word bits 31 down to 0.
- R3: The MDIO output changes only together with an MDC falling edge or at frame start. It holds steady while MDC is high.
- R4: A write operation (bit 28 = 1, bit 29 = 0) keeps the output enable high for all 64 bits and leaves the command word as written.
- R5: A read operation (bit 29 = 1, bit 28 = 0) drops the output enable for the last 17 frame bits. It samples MDIO input on the rising edges of the final 16 bits, first bit to bit 15, and on completion replaces command bits 15:0 with the captured value while bits 31:16 are kept.
- R6: The idle flag goes to 0 in the cycle after a command is accepted. It returns to 1 half an MDC period after the 64th rising edge, when the final falling edge occurs.
- R7: A command word written while a frame is in progress is ignored: the stored word and the frame on the pin are unchanged, and no further frame follows.
- R8: A command word written while the enable bit (control bit 4) is 0 is ignored: no MDC edge occurs and the stored word is unchanged.
- R9: Configuration bits 20:18 select the MDC period in system clocks, with 0..7 giving 8, 16, 32, 48, 64, 96, 128 and 224. MDC is high for exactly half of each period, and the selection is captured when a command is accepted.
- R10: Register address 0 is control (enable at bit 4), 1 is configuration, 2 is the read-only status register and 3 is the command word. Bits the block does not implement read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench uses a PHY model that drives a known 16-bit pattern only on the data bits of a read. A design that samples on the wrong MDC edge, or that is off by one bit, returns a shifted value in bits 15:0. A design that releases the pin one bit too early or too late shows up in the recorded output-enable sequence. A second command written in the middle of a frame must neither restart the frame nor overwrite the stored word. The idle flag is timed against the last rising edge, so a design that frees the port before its final falling edge is caught. The MDC period and high time are measured for divider selects 2 and 3, which catches swapped or miscomputed divide ratios.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int RATIO_W  = 8;
  localparam int DIVSEL_W = 3;

  // bit positions that software depends on
  localparam int EN_BIT   = 4;
  localparam int IDLE_BIT = 2;
  localparam int DIV_LSB  = 18;
  localparam int RD_BIT   = 29;
  localparam int WR_BIT   = 28;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_CFG  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_CMD  = 2'd3;

  // system clocks per MDC period for each divider select
  function automatic logic [RATIO_W-1:0] mdc_ratio(input logic [DIVSEL_W-1:0] sel);
    case (sel)
      3'd0:    mdc_ratio = 8'd8;
      3'd1:    mdc_ratio = 8'd16;
      3'd2:    mdc_ratio = 8'd32;
      3'd3:    mdc_ratio = 8'd48;
      3'd4:    mdc_ratio = 8'd64;
      3'd5:    mdc_ratio = 8'd96;
      3'd6:    mdc_ratio = 8'd128;
      default: mdc_ratio = 8'd224;
    endcase
  endfunction

  function automatic logic is_read_op(input logic [CMD_W-1:0] w);
    is_read_op = w[RD_BIT] & ~w[WR_BIT];
  endfunction
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               mdc,
  output logic               rise_tick,
  output logic               bit_end
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half_m1;

  assign half_m1   = (ratio >> 1) - RATIO_W'(1);
  assign rise_tick = run && (cnt == half_m1);
  assign bit_end   = run && (cnt == ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= bit_end ? '0 : cnt + RATIO_W'(1);
      if (rise_tick)    mdc <= 1'b1;
      else if (bit_end) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_tick,
  input  logic              bit_end,
  input  logic              mdio_i,
  output logic              busy,
  output logic              rd_op,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_W = PRE_BITS + CMD_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               in_rx;

  // pin released from the second turnaround bit onward
  assign in_rx   = rd_op && (idx <= IDX_W'(DATA_W));
  assign done    = busy && bit_end && (idx == '0);
  assign mdio_o  = busy & shreg[FRAME_W-1];
  assign mdio_oe = busy & ~in_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      rd_op   <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      shreg <= {{PRE_BITS{1'b1}}, cmd};
      idx   <= IDX_W'(FRAME_W - 1);
      busy  <= 1'b1;
      rd_op <= is_read_op(cmd);
    end else if (busy) begin
      if (rise_tick && rd_op && (idx < IDX_W'(DATA_W)))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (bit_end) begin
        if (idx == '0) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx - IDX_W'(1);
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                en_q;
  logic [DIVSEL_W-1:0] div_sel_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [RATIO_W-1:0]  ratio_q;

  // named events for the checker
  logic busy, rd_op, frame_done, start_acc, rise_tick, bit_end;
  logic [DATA_W-1:0] rd_data;

  assign start_acc = reg_we && (reg_addr == RA_CMD) && en_q && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      div_sel_q <= DIVSEL_W'(2);
      cmd_q     <= '0;
      ratio_q   <= mdc_ratio(DIVSEL_W'(2));
    end else begin
      if (reg_we && reg_addr == RA_CTRL) en_q      <= reg_wdata[EN_BIT];
      if (reg_we && reg_addr == RA_CFG)  div_sel_q <= reg_wdata[DIV_LSB +: DIVSEL_W];
      if (start_acc) begin
        cmd_q   <= reg_wdata;
        ratio_q <= mdc_ratio(div_sel_q);
      end else if (frame_done && rd_op) begin
        cmd_q[DATA_W-1:0] <= rd_data;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[EN_BIT] = en_q;
      RA_CFG:  reg_rdata[DIV_LSB +: DIVSEL_W] = div_sel_q;
      RA_STAT: reg_rdata[IDLE_BIT] = ~busy;
      default: reg_rdata = cmd_q;
    endcase
  end

  mdc_clkgen u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .ratio     (ratio_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .bit_end   (bit_end)
  );

  mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_acc),
    .cmd       (reg_wdata),
    .rise_tick (rise_tick),
    .bit_end   (bit_end),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .rd_op     (rd_op),
    .done      (frame_done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        frame_done,
  input logic        en_q,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] cmd_q
);
  // R3
  mdio_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(mdc) && !$rose(busy)) |-> $stable(mdio_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_q));

  // R6
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  // R7
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && busy && !frame_done) |=> $stable(cmd_q));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .busy       (busy),
  .frame_done (frame_done),
  .en_q       (en_q),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .cmd_q      (cmd_q)
);

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  always #4 clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0;
  int rises = 0, r3_bad = 0;
  logic [63:0] frm = '0, oe_seq = '0;
  logic [15:0] phy_val = '0;
  logic last_rise_o = 1'b0;
  realtime t_prev = 0, per_last = 0, hi_last = 0;
  bit finished = 0;

  // frame monitor
  always @(posedge mdc) begin
    frm         = {frm[62:0], mdio_o};
    oe_seq      = {oe_seq[62:0], mdio_oe};
    last_rise_o = mdio_o;
    per_last    = $realtime - t_prev;
    t_prev      = $realtime;
    rises       = rises + 1;
  end
  always @(negedge mdc) hi_last = $realtime - t_prev;
  always @(negedge clk) if (mdc && mdio_o !== last_rise_o) r3_bad++;

  // PHY model: zero on second turnaround, data on last 16 bits, ones otherwise
  always_comb begin
    if (rises >= 48 && rises < 64) mdio_i = phy_val[63 - rises];
    else if (rises == 47)          mdio_i = 1'b0;
    else                           mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // runs one frame, checks idle timing (R6), pin steadiness (R3), edge count (R2)
  task automatic do_frame(input logic [31:0] cmd, input int ratio);
    logic [31:0] s;
    int n;
    rises = 0; r3_bad = 0;
    wr(2'd3, cmd);
    rd(2'd2, s);
    check(s[2] == 1'b0, "R6 busy after accept", s, 32'h0);
    while (rises < 64) @(negedge clk);
    rd(2'd2, s);
    check(s[2] == 1'b0, "R6 busy at last rise", s, 32'h0);
    n = 0;
    do begin
      @(negedge clk); n++; rd(2'd2, s);
    end while (s[2] == 1'b0 && n < 1000);
    check(n == ratio / 2, "R6 idle delay", 64'(n), 64'(ratio / 2));
    repeat (3) @(negedge clk);
    check(rises == 64, "R2 rising edges", 64'(rises), 64'd64);
    check(r3_bad == 0, "R3 mdio steady while mdc high", 64'(r3_bad), 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check(d == 32'h0, "R1 ctrl reset", d, 32'h0);
    rd(2'd1, d); check(d == 32'h0008_0000, "R1 cfg reset", d, 32'h0008_0000);
    rd(2'd2, d); check(d == 32'h4, "R1 status reset", d, 32'h4);
    rd(2'd3, d); check(d == 32'h0, "R1 cmd reset", d, 32'h0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFEF);
    rd(2'd0, d); check(d == 32'h0, "R10 ctrl unused bits", d, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check(d == 32'h001C_0000, "R10 cfg field only", d, 32'h001C_0000);
    wr(2'd2, 32'h0);
    rd(2'd2, d); check(d == 32'h4, "R10 status read only", d, 32'h4);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    rises = 0;
    wr(2'd3, 32'h5082_0000);
    repeat (40) @(negedge clk);
    check(rises == 0, "R8 no frame when disabled", 64'(rises), 64'd0);
    rd(2'd3, d); check(d == 32'h0, "R8 cmd unchanged", d, 32'h0);
    rd(2'd2, d); check(d == 32'h4, "R8 still idle", d, 32'h4);
  endtask

  task automatic t_write();
    logic [31:0] cmd, d;
    cmd = 32'h5000_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'h0002_0000 | 32'h0000_BEEF;
    do_frame(cmd, 8);
    check(frm == {32'hFFFF_FFFF, cmd}, "R2 write frame bits", frm, {32'hFFFF_FFFF, cmd});
    check(oe_seq == 64'hFFFF_FFFF_FFFF_FFFF, "R4 oe held on write", oe_seq, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, d); check(d == cmd, "R4 word unchanged after write", d, cmd);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] fill, input logic [15:0] reply);
    logic [31:0] cmd, d;
    logic [63:0] expf;
    phy_val = reply;
    cmd = 32'h6000_0000 | (32'(phy) << 23) | (32'(rg) << 18) | 32'h0002_0000 | 32'(fill);
    expf = {32'hFFFF_FFFF, cmd};
    do_frame(cmd, 8);
    check(frm[63:17] == expf[63:17], "R2 read header bits", frm, expf);
    check(oe_seq == 64'hFFFF_FFFF_FFFE_0000, "R5 oe released for 17 bits", oe_seq, 64'hFFFF_FFFF_FFFE_0000);
    rd(2'd3, d);
    check(d == {cmd[31:16], reply}, "R5 read data in place", d, {cmd[31:16], reply});
  endtask

  task automatic t_busy_write();
    logic [31:0] a, b, d;
    int n;
    a = 32'h5000_0000 | (32'd9 << 23) | (32'd4 << 18) | 32'h0002_0000 | 32'h0000_1357;
    b = 32'h6000_0000 | (32'd2 << 23) | (32'd7 << 18) | 32'h0002_0000;
    rises = 0;
    wr(2'd3, a);
    repeat (100) @(negedge clk);
    wr(2'd3, b);
    rd(2'd3, d); check(d == a, "R7 word kept during busy write", d, a);
    n = 0;
    do begin @(negedge clk); n++; rd(2'd2, d); end while (d[2] == 1'b0 && n < 2000);
    repeat (40) @(negedge clk);
    check(rises == 64, "R7 no extra frame", 64'(rises), 64'd64);
    check(frm == {32'hFFFF_FFFF, a}, "R7 frame unaffected", frm, {32'hFFFF_FFFF, a});
    rd(2'd3, d); check(d == a, "R7 word after frame", d, a);
  endtask

  task automatic t_divider(input logic [2:0] sel, input int ratio);
    logic [31:0] cmd;
    wr(2'd1, 32'(sel) << 18);
    cmd = 32'h5000_0000 | (32'd1 << 23) | 32'h0002_0000 | 32'h0000_00A5;
    do_frame(cmd, ratio);
    check(int'(per_last / 8.0) == ratio, "R9 mdc period", 64'(int'(per_last / 8.0)), 64'(ratio));
    check(int'(hi_last / 8.0) == ratio / 2, "R9 mdc high time", 64'(int'(hi_last / 8.0)), 64'(ratio / 2));
    wr(2'd1, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_disabled();
    wr(2'd0, 32'h10);
    t_write();
    t_read(5'd17, 5'd1, 16'h0000, 16'hA5C3);
    t_read(5'd31, 5'd30, 16'h1234, 16'h8001);
    t_busy_write();
    t_divider(3'd2, 32);
    t_divider(3'd3, 48);
    summary();
  end
endmodule